// File: doc/BRIEF.md
# Carry-Word-Select Adder

This block adds two unsigned W-bit operands and a carry-in and returns a W-bit sum and a carry-out. It is purely combinational: there is no clock and no reset, and the outputs follow the inputs after the logic settles.

Internally it follows the carry-select idea with one change. It does not build two complete sum words and throw one away. Instead it builds two carry words from a shared half-sum and half-carry layer. One carry word assumes the incoming carry is 0 and the other assumes it is 1. The real carry-in picks one of the two carry words, and the final sum is then formed from the picked word.

The width is a parameter, and the block is meant to be dropped into datapaths anywhere from a byte up to 128 bits wide.

Top module: `cws_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals the unsigned (W+1)-bit value opa_i + opb_i + cin_i.
- R2: sum_o bit 0 equals opa_i bit 0 XOR opb_i bit 0 XOR cin_i.
- R3: The carry word built for an assumed carry-in of 1 holds a 1 in every position where the word for an assumed carry-in of 0 holds a 1. As a consequence, with the operands held fixed, raising cin_i from 0 to 1 raises the (W+1)-bit result {cout_o, sum_o} by exactly one.
- R4: With both operands zero, sum_o equals cin_i zero-extended and cout_o is 0.
- R5: When opb_i is the bitwise complement of opa_i, the carry ripples through every bit. With cin_i = 0 the result is sum_o all ones and cout_o = 0. With cin_i = 1 the result is sum_o all zeros and cout_o = 1.
- R6: With both operands all ones, cout_o is 1, sum_o bit 0 equals cin_i, and every other sum_o bit is 1.
- R7: At W = 128, opa_i = 45, opb_i = 4 and cin_i = 1 give sum_o = 50 and cout_o = 0.
- R8: R1 holds at widths 8, 16, 32, 64 and 128 set through the parameter W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First unsigned operand |
| opb_i | input | W | Second unsigned operand |
| cin_i | input | 1 | Incoming carry |
| sum_o | output | W | Low W bits of the total |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Random operand pairs are applied at every width with both carry-in values, and each result is compared with a behavioural sum. These runs catch errors in the per-bit carry recurrence and in the carry-word mux.

All-zero operands separate the carry-in path into bit 0 from everything else. Complementary operands force the longest carry chain, so only a correct top-bit carry and correct propagation give the expected result. All-ones operands exercise generate at every position, and alternating bit patterns distinguish a carry that is dropped or shifted by one position.

Holding the operands fixed while toggling the carry-in isolates the final selection step.

// File: rtl/cws_adder.sv
`timescale 1ns/1ps
module cws_adder #(
  parameter int W = 128
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] hs, hc, cw0, cw1, csel;

  assign hs = opa_i ^ opb_i;
  assign hc = opa_i & opb_i;

  assign cw0[0] = hc[0];
  assign cw1[0] = hc[0] | hs[0];

  for (genvar i = 1; i < W; i++) begin : g_cgen
    assign cw0[i] = hc[i] | (hs[i] & cw0[i-1]);
    assign cw1[i] = hc[i] | (hs[i] & cw1[i-1]);
  end

  assign csel   = cin_i ? cw1 : cw0;
  assign cout_o = csel[W-1];

  assign sum_o[0] = hs[0] ^ cin_i;
  if (W > 1) begin : g_upper
    assign sum_o[W-1:1] = hs[W-1:1] ^ csel[W-2:0];
  end
endmodule

// File: rtl/cws_adder_chk.sv
`timescale 1ns/1ps
module cws_adder_chk #(
  parameter int W = 128
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic [W-1:0] cw0,
  input logic [W-1:0] cw1
);
  logic [W:0] ref_w;
  assign ref_w = {1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    a_r1_total_matches: assert ({cout_o, sum_o} == ref_w);
    a_r2_low_bit: assert (sum_o[0] == (opa_i[0] ^ opb_i[0] ^ cin_i));
    a_r3_carry_words_ordered: assert ((cw0 & ~cw1) == '0);
    if (opa_i == '0 && opb_i == '0)
      a_r4_zero_operands: assert (cout_o == 1'b0 && sum_o == {{(W-1){1'b0}}, cin_i});
    if (opb_i == ~opa_i)
      a_r5_full_ripple: assert (cout_o == cin_i && sum_o == {W{~cin_i}});
  end
endmodule

bind cws_adder cws_adder_chk #(.W(W)) u_chk (
  .opa_i(opa_i), .opb_i(opb_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .cw0(cw0), .cw1(cw1)
);

// File: tb/test_cws_adder.sv
`timescale 1ns/1ps
module cws_lane #(
  parameter int W = 8
) (
  input  logic clk,
  output int   n_pass,
  output int   n_total,
  output logic done
);
  logic [W-1:0] a, b;
  logic         ci;
  logic [W-1:0] s;
  logic         co;
  logic [W:0]   exp_q[$];
  string        tag_q[$];

  cws_adder #(.W(W)) i_cws_adder (.opa_i(a), .opb_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v = '0;
    for (int k = 0; k < (W + 31) / 32; k++) v = W'({v, $urandom()});
    return v;
  endfunction

  function automatic logic [W-1:0] alt(logic b0);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (i % 2 == 0) ? b0 : ~b0;
    return v;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
    @(posedge clk);
    a  = x;
    b  = y;
    ci = c;
    exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c});
    tag_q.push_back(tag);
  endtask

  initial begin
    n_pass = 0;
    n_total = 0;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_total++;
        if ({co, s} === e) n_pass++;
        else $display("FAIL %s W=%0d actual=%h expected=%h", t, W, {co, s}, e);
      end
    end
  end

  initial begin
    done = 1'b0;
    a = '0; b = '0; ci = 1'b0;
    drive('0, '0, 1'b0, "R4 zeros cin0");
    drive('0, '0, 1'b1, "R4 zeros cin1");
    begin
      logic [W-1:0] x = rnd();
      drive(x, ~x, 1'b0, "R5 complement cin0");
      drive(x, ~x, 1'b1, "R5 complement cin1");
    end
    drive('0, '1, 1'b1, "R5 ripple from zero");
    drive('1, '1, 1'b0, "R6 all ones cin0");
    drive('1, '1, 1'b1, "R6 all ones cin1");
    drive(alt(1'b0), alt(1'b0), 1'b0, "R8 alternating same");
    drive(alt(1'b1), alt(1'b0), 1'b1, "R8 alternating opposite");
    drive(alt(1'b1), alt(1'b1), 1'b1, "R8 alternating generate");
    drive(W'(45), W'(4), 1'b1, "R7 45+4+1");
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] x = rnd();
      logic [W-1:0] y = rnd();
      drive(x, y, 1'b0, "R3 fixed operands cin0");
      drive(x, y, 1'b1, "R3 fixed operands cin1");
      drive(rnd(), rnd(), 1'($urandom()), "R1 random");
      drive(x, y, ~x[0], "R2 low bit");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end
endmodule

module test_cws_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int   p8, t8, p16, t16, p32, t32, p64, t64, p128, t128;
  logic d8, d16, d32, d64, d128;

  cws_lane #(.W(8))   u_w8   (.clk(clk), .n_pass(p8),   .n_total(t8),   .done(d8));
  cws_lane #(.W(16))  u_w16  (.clk(clk), .n_pass(p16),  .n_total(t16),  .done(d16));
  cws_lane #(.W(32))  u_w32  (.clk(clk), .n_pass(p32),  .n_total(t32),  .done(d32));
  cws_lane #(.W(64))  u_w64  (.clk(clk), .n_pass(p64),  .n_total(t64),  .done(d64));
  cws_lane #(.W(128)) i_cws_adder (.clk(clk), .n_pass(p128), .n_total(t128), .done(d128));

  initial begin
    int cyc = 0;
    int passed;
    int total;
    logic hung = 1'b0;
    while (!(d8 === 1'b1 && d16 === 1'b1 && d32 === 1'b1 && d64 === 1'b1 && d128 === 1'b1)) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        hung = 1'b1;
        break;
      end
    end
    @(negedge clk);
    passed = p8 + p16 + p32 + p64 + p128;
    total  = t8 + t16 + t32 + t64 + t128;
    if (hung) begin
      total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule